// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block carries out cache-maintenance commands against a four-way, set-associative cache whose lines are 16 bytes long and whose 32-bit longwords each carry their own dirty bit. A single command pulse delivers a 16-bit maintenance opcode. The opcode picks one or both caches, a scope, and whether dirty data must be written back. It also names one of eight address registers. The block receives all eight register values and the page-size selector at its ports.

For line and page scopes, the block steps through the covered address range in line-sized increments. It reads each indexed set from the selected cache array and compares the stored tags of all ways with the tag of the stepped address. For every valid way that matches, it writes the dirty longwords to memory if a push was requested, then clears that way's valid and dirty bits. The whole-cache scope performs no walk: it issues a single flash clear of the valid bits. At the start of every command the block pulses a kill signal that discards the fetch unit's line buffer. The array read port has one cycle of latency, as a block RAM does. The memory write port uses a valid/ready handshake.

Top module: `cache_maint_seq`

## Requirements
- R1: Opcode bit 6 selects the data cache (`arr_sel`=0) and bit 7 selects the instruction cache (`arr_sel`=1). When both are set, the data cache is processed completely before the instruction cache. When neither is set, the command touches no array and no memory, and still ends with `done`. Opcode bits [15:8] have no effect.
- R2: When opcode bits [4:3] equal 3, the block pulses `arr_clr_all` once for each selected cache and clears valid bits only. It issues no array reads and no memory writes.
- R3: When opcode bits [4:3] are 0 or 1, the block processes exactly one line: the register value aligned down to 16 bytes. The set index is address bits [9:4] and the tag is bits [31:10].
- R4: When opcode bits [4:3] equal 2, the block processes one page, 8192 bytes if `page8k` is 1 and 4096 bytes otherwise. The start address is the register value aligned down to the page size. Lines are visited in ascending 16-byte steps, with one array read per line per cache.
- R5: Opcode bits [2:0] choose which of the eight register values supplies the target address. Register n occupies `areg_flat[32n+31:32n]`.
- R6: For each visited line, every valid way whose tag matches has its valid bit and all four dirty bits cleared. Ways that do not match, and all other sets, keep their valid and dirty bits.
- R7: When opcode bit 5 is 1, each dirty longword l of a matching way is written to memory at line address + 4·l with its cached data. Writes go in ascending way order, then ascending longword order. When bit 5 is 0, no memory write occurs.
- R8: A memory write offered while `mem_wr_ready` is low stays offered, with the same address and data, until it is accepted. A write counts only when `mem_wr_en` and `mem_wr_ready` are both high at a clock edge.
- R9: Each accepted command produces exactly one single-cycle `fetch_buf_kill` pulse, in the cycle in which `busy` first rises.
- R10: `busy` rises the cycle after an accepted `start` and stays high until the last write-back and invalidation are finished. It then falls in the same cycle as a one-cycle `done` pulse. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command pulse, taken only while idle |
| opcode | input | 16 | Maintenance opcode |
| areg_flat | input | 256 | Eight 32-bit address register values, register n at bits [32n+31:32n] |
| page8k | input | 1 | 1 selects an 8 KB page, 0 a 4 KB page |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| fetch_buf_kill | output | 1 | One-cycle pulse that invalidates the fetch line buffer |
| arr_sel | output | 1 | Array targeted: 0 data cache, 1 instruction cache |
| arr_rd_en | output | 1 | Set read request |
| arr_rd_set | output | 6 | Set index to read |
| arr_rd_valid | input | 4 | Valid bits of the read set, one per way |
| arr_rd_tag | input | 88 | Tags of the read set, way w at bits [22w+21:22w] |
| arr_rd_dirty | input | 16 | Dirty bits, bit 4w+l for way w longword l |
| arr_rd_data | input | 512 | Line data, longword (4w+l) at bits [32(4w+l)+31 : 32(4w+l)] |
| arr_wr_en | output | 1 | Invalidate request for the ways in `arr_wr_ways` |
| arr_wr_set | output | 6 | Set index for the invalidate request |
| arr_wr_ways | output | 4 | Ways whose valid and dirty bits are cleared |
| arr_clr_all | output | 1 | Flash clear of every valid bit in the selected array |
| mem_wr_en | output | 1 | Memory write offered |
| mem_wr_addr | output | 32 | Byte address of the longword being written |
| mem_wr_data | output | 32 | Longword being written |
| mem_wr_ready | input | 1 | Memory accepts the offered write |

## Verification
The assertions assume that the array port returns data exactly one cycle after a read request. They also assume that the memory side does not depend on `mem_wr_en` being withdrawn before it is accepted. The bench models both arrays with a one-cycle registered read and drives `mem_wr_ready` low at random, about one cycle in four, so that the hold rule is exercised. Commands are issued only from idle, apart from one deliberate `start` injected mid-command to confirm that it is ignored. Tags are preloaded so that many ways fall inside the target page, which makes hits, dirty pushes and repeated visits to the same set frequent.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

  localparam int REG_COUNT = 8;

  typedef enum logic [1:0] {
    SC_LINE = 2'd0,
    SC_PAGE = 2'd1,
    SC_ALL  = 2'd2
  } scope_e;

  typedef struct packed {
    logic [1:0] caches;
    scope_e     scope;
    logic       push;
    logic [2:0] reg_sel;
  } maint_op_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PICK,
    ST_RD,
    ST_WAIT,
    ST_CMP,
    ST_WB,
    ST_INV,
    ST_STEP,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/cmaint_decode.sv
module cmaint_decode
  import cmaint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SMALL = 4096,
  parameter int PAGE_LARGE = 8192,
  parameter int LINE_BYTES = 16,
  parameter int STEP_W     = 10
) (
  input  logic [15:0]                 opcode,
  input  logic [REG_COUNT*ADDR_W-1:0] areg_flat,
  input  logic                        page8k,
  output maint_op_t                   op_o,
  output logic [ADDR_W-1:0]           base_o,
  output logic [STEP_W-1:0]           steps_o
);

  localparam int STEPS_S = PAGE_SMALL / LINE_BYTES;
  localparam int STEPS_L = PAGE_LARGE / LINE_BYTES;
  localparam logic [ADDR_W-1:0] SPAN_S    = ADDR_W'(PAGE_SMALL);
  localparam logic [ADDR_W-1:0] SPAN_L    = ADDR_W'(PAGE_LARGE);
  localparam logic [ADDR_W-1:0] SPAN_LINE = ADDR_W'(LINE_BYTES);

  logic [ADDR_W-1:0] sel_addr;
  logic [ADDR_W-1:0] span;

  always_comb begin
    op_o.caches  = opcode[7:6];
    op_o.push    = opcode[5];
    op_o.reg_sel = opcode[2:0];
    case (opcode[4:3])
      2'b11:   op_o.scope = SC_ALL;
      2'b10:   op_o.scope = SC_PAGE;
      default: op_o.scope = SC_LINE;
    endcase

    sel_addr = areg_flat[opcode[2:0]*ADDR_W +: ADDR_W];

    if (op_o.scope == SC_PAGE) begin
      span    = page8k ? SPAN_L : SPAN_S;
      steps_o = page8k ? STEP_W'(STEPS_L) : STEP_W'(STEPS_S);
    end else begin
      span    = SPAN_LINE;
      steps_o = STEP_W'(1);
    end
    base_o = sel_addr & ~(span - ADDR_W'(1));
  end

endmodule

// File: rtl/cmaint_tag_cmp.sv
module cmaint_tag_cmp #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 22
) (
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS*TAG_W-1:0] way_tags,
  input  logic [TAG_W-1:0]      probe_tag,
  output logic [WAYS-1:0]       hit
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == probe_tag);
  end

endmodule

// File: rtl/cmaint_wb_pick.sv
module cmaint_wb_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     pending,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending[i]) idx = IDX_W'(i);
    end
    any = |pending;
  end

endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq
  import cmaint_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int PAGE_SMALL = 4096,
  parameter int PAGE_LARGE = 8192,
  localparam int LINE_BYTES = 16,
  localparam int LWS        = LINE_BYTES / (DATA_W / 8),
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int SET_W      = $clog2(SETS),
  localparam int TAG_W      = ADDR_W - SET_W - OFF_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [15:0]                 opcode,
  input  logic [REG_COUNT*ADDR_W-1:0] areg_flat,
  input  logic                        page8k,
  output logic                        busy,
  output logic                        done,
  output logic                        fetch_buf_kill,
  output logic                        arr_sel,
  output logic                        arr_rd_en,
  output logic [SET_W-1:0]            arr_rd_set,
  input  logic [WAYS-1:0]             arr_rd_valid,
  input  logic [WAYS*TAG_W-1:0]       arr_rd_tag,
  input  logic [WAYS*LWS-1:0]         arr_rd_dirty,
  input  logic [WAYS*LWS*DATA_W-1:0]  arr_rd_data,
  output logic                        arr_wr_en,
  output logic [SET_W-1:0]            arr_wr_set,
  output logic [WAYS-1:0]             arr_wr_ways,
  output logic                        arr_clr_all,
  output logic                        mem_wr_en,
  output logic [ADDR_W-1:0]           mem_wr_addr,
  output logic [DATA_W-1:0]           mem_wr_data,
  input  logic                        mem_wr_ready
);

  localparam int NPEND  = WAYS * LWS;
  localparam int PIDX_W = $clog2(NPEND);
  localparam int LW_W   = $clog2(LWS);
  localparam int BSH    = $clog2(DATA_W / 8);
  localparam int STEP_W = $clog2(PAGE_LARGE / LINE_BYTES) + 1;

  seq_state_e                state;
  maint_op_t                 op_q;
  logic [ADDR_W-1:0]         base_q;
  logic [STEP_W-1:0]         nsteps_q;
  logic [STEP_W-1:0]         step_q;
  logic [ADDR_W-1:0]         line_addr_q;
  logic [1:0]                left_q;
  logic [WAYS-1:0]           hit_q;
  logic [NPEND-1:0]          pend_q;
  logic [NPEND*DATA_W-1:0]   data_q;

  maint_op_t                 dec_op;
  logic [ADDR_W-1:0]         dec_base;
  logic [STEP_W-1:0]         dec_steps;
  logic [WAYS-1:0]           hit_now;
  logic [NPEND-1:0]          pend_now;
  logic                      pick_any;
  logic [PIDX_W-1:0]         pick_idx;
  logic [SET_W-1:0]          cur_set;
  logic [TAG_W-1:0]          cur_tag;

  assign cur_set = line_addr_q[OFF_W +: SET_W];
  assign cur_tag = line_addr_q[ADDR_W-1 -: TAG_W];

  cmaint_decode #(
    .ADDR_W(ADDR_W), .PAGE_SMALL(PAGE_SMALL), .PAGE_LARGE(PAGE_LARGE),
    .LINE_BYTES(LINE_BYTES), .STEP_W(STEP_W)
  ) u_dec (
    .opcode(opcode), .areg_flat(areg_flat), .page8k(page8k),
    .op_o(dec_op), .base_o(dec_base), .steps_o(dec_steps)
  );

  cmaint_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
    .way_valid(arr_rd_valid), .way_tags(arr_rd_tag),
    .probe_tag(cur_tag), .hit(hit_now)
  );

  cmaint_wb_pick #(.N(NPEND), .IDX_W(PIDX_W)) u_pick (
    .pending(pend_q), .any(pick_any), .idx(pick_idx)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_pend_way
    for (genvar l = 0; l < LWS; l++) begin : g_pend_lw
      assign pend_now[w*LWS+l] = op_q.push && hit_now[w] && arr_rd_dirty[w*LWS+l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      op_q           <= '0;
      base_q         <= '0;
      nsteps_q       <= '0;
      step_q         <= '0;
      line_addr_q    <= '0;
      left_q         <= '0;
      hit_q          <= '0;
      pend_q         <= '0;
      data_q         <= '0;
      busy           <= 1'b0;
      done           <= 1'b0;
      fetch_buf_kill <= 1'b0;
      arr_sel        <= 1'b0;
      arr_rd_en      <= 1'b0;
      arr_rd_set     <= '0;
      arr_wr_en      <= 1'b0;
      arr_wr_set     <= '0;
      arr_wr_ways    <= '0;
      arr_clr_all    <= 1'b0;
      mem_wr_en      <= 1'b0;
      mem_wr_addr    <= '0;
      mem_wr_data    <= '0;
    end else begin
      done           <= 1'b0;
      fetch_buf_kill <= 1'b0;
      arr_rd_en      <= 1'b0;
      arr_wr_en      <= 1'b0;
      arr_clr_all    <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (start) begin
            op_q           <= dec_op;
            base_q         <= dec_base;
            nsteps_q       <= dec_steps;
            left_q         <= dec_op.caches;
            busy           <= 1'b1;
            fetch_buf_kill <= 1'b1;
            state          <= ST_PICK;
          end
        end

        ST_PICK: begin
          if (left_q == 2'b00) begin
            state <= ST_DONE;
          end else begin
            arr_sel <= ~left_q[0];
            left_q  <= left_q[0] ? {left_q[1], 1'b0} : 2'b00;
            if (op_q.scope == SC_ALL) begin
              arr_clr_all <= 1'b1;
            end else begin
              line_addr_q <= base_q;
              step_q      <= '0;
              state       <= ST_RD;
            end
          end
        end

        ST_RD: begin
          arr_rd_en  <= 1'b1;
          arr_rd_set <= cur_set;
          state      <= ST_WAIT;
        end

        ST_WAIT: state <= ST_CMP;

        ST_CMP: begin
          hit_q  <= hit_now;
          pend_q <= pend_now;
          data_q <= arr_rd_data;
          if (hit_now == '0)      state <= ST_STEP;
          else if (pend_now != '0) state <= ST_WB;
          else                    state <= ST_INV;
        end

        ST_WB: begin
          if (mem_wr_en && !mem_wr_ready) begin
            mem_wr_en <= 1'b1;
          end else if (pick_any) begin
            mem_wr_en        <= 1'b1;
            mem_wr_addr      <= line_addr_q + (ADDR_W'(pick_idx[LW_W-1:0]) << BSH);
            mem_wr_data      <= data_q[pick_idx*DATA_W +: DATA_W];
            pend_q[pick_idx] <= 1'b0;
          end else begin
            mem_wr_en <= 1'b0;
            state     <= ST_INV;
          end
        end

        ST_INV: begin
          arr_wr_en   <= 1'b1;
          arr_wr_set  <= cur_set;
          arr_wr_ways <= hit_q;
          state       <= ST_STEP;
        end

        ST_STEP: begin
          if (step_q == nsteps_q - STEP_W'(1)) begin
            state <= ST_PICK;
          end else begin
            step_q      <= step_q + STEP_W'(1);
            line_addr_q <= line_addr_q + ADDR_W'(LINE_BYTES);
            state       <= ST_RD;
          end
        end

        ST_DONE: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmaint_checker.sv
module cmaint_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              fetch_buf_kill,
  input logic              arr_rd_en,
  input logic              arr_wr_en,
  input logic              arr_clr_all,
  input logic              mem_wr_en,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data
);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_kill_at_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> fetch_buf_kill);

  p_kill_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    fetch_buf_kill |=> !fetch_buf_kill);

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && !mem_wr_ready) |=>
      (mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_wr_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_wr_addr[1:0] == 2'b00));

  p_activity_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (arr_rd_en || arr_wr_en || arr_clr_all || mem_wr_en) |-> busy);

  p_clear_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    arr_clr_all |-> (!arr_rd_en && !mem_wr_en && !arr_wr_en));

endmodule

bind cache_maint_seq cmaint_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .fetch_buf_kill(fetch_buf_kill), .arr_rd_en(arr_rd_en),
  .arr_wr_en(arr_wr_en), .arr_clr_all(arr_clr_all),
  .mem_wr_en(mem_wr_en), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
);

// File: tb/tb_cache_maint_seq.sv
`timescale 1ns/1ps
module tb_cache_maint_seq;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [15:0]  opcode = '0;
  logic [255:0] areg_flat = '0;
  logic         page8k = 1'b0;
  logic         busy, done, fetch_buf_kill, arr_sel, arr_rd_en;
  logic [5:0]   arr_rd_set;
  logic [3:0]   arr_rd_valid = '0;
  logic [87:0]  arr_rd_tag = '0;
  logic [15:0]  arr_rd_dirty = '0;
  logic [511:0] arr_rd_data = '0;
  logic         arr_wr_en;
  logic [5:0]   arr_wr_set;
  logic [3:0]   arr_wr_ways;
  logic         arr_clr_all, mem_wr_en;
  logic [31:0]  mem_wr_addr, mem_wr_data;
  logic         mem_wr_ready = 1'b0;

  always #4 clk = ~clk;

  cache_maint_seq dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .areg_flat(areg_flat),
    .page8k(page8k), .busy(busy), .done(done), .fetch_buf_kill(fetch_buf_kill),
    .arr_sel(arr_sel), .arr_rd_en(arr_rd_en), .arr_rd_set(arr_rd_set),
    .arr_rd_valid(arr_rd_valid), .arr_rd_tag(arr_rd_tag), .arr_rd_dirty(arr_rd_dirty),
    .arr_rd_data(arr_rd_data), .arr_wr_en(arr_wr_en), .arr_wr_set(arr_wr_set),
    .arr_wr_ways(arr_wr_ways), .arr_clr_all(arr_clr_all), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready)
  );

  // cache model: [cache][set][way]
  logic [21:0] m_tag   [2][64][4];
  logic        m_val   [2][64][4];
  logic [3:0]  m_dirty [2][64][4];
  logic [31:0] m_data  [2][64][4][4];
  logic        e_val   [2][64][4];
  logic [3:0]  e_dirty [2][64][4];

  logic [31:0] a_wa [4096];
  logic [31:0] a_wd [4096];
  logic [31:0] e_wa [4096];
  logic [31:0] e_wd [4096];
  int a_wn, e_wn, rd_cnt, e_rd, clr_cnt, e_clr, kill_cnt, hold_viol, wr_other;
  logic clr_sel_log [4];
  logic e_clr_sel   [4];
  logic prev_hold;
  logic [31:0] prev_addr, prev_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (arr_rd_en) begin
      rd_cnt++;
      for (int w = 0; w < 4; w++) begin
        arr_rd_valid[w] <= m_val[arr_sel][arr_rd_set][w];
        arr_rd_tag[w*22 +: 22] <= m_tag[arr_sel][arr_rd_set][w];
        arr_rd_dirty[w*4 +: 4] <= m_dirty[arr_sel][arr_rd_set][w];
        for (int l = 0; l < 4; l++)
          arr_rd_data[(w*4+l)*32 +: 32] <= m_data[arr_sel][arr_rd_set][w][l];
      end
    end
    if (arr_wr_en) begin
      for (int w = 0; w < 4; w++) begin
        if (arr_wr_ways[w]) begin
          m_val[arr_sel][arr_wr_set][w] = 1'b0;
          m_dirty[arr_sel][arr_wr_set][w] = 4'h0;
        end
      end
    end
    if (arr_clr_all) begin
      if (clr_cnt < 4) clr_sel_log[clr_cnt] = arr_sel;
      clr_cnt++;
      for (int s = 0; s < 64; s++)
        for (int w = 0; w < 4; w++) m_val[arr_sel][s][w] = 1'b0;
    end
    if (prev_hold && !(mem_wr_en && mem_wr_addr == prev_addr && mem_wr_data == prev_data))
      hold_viol++;
    prev_hold = mem_wr_en && !mem_wr_ready;
    prev_addr = mem_wr_addr;
    prev_data = mem_wr_data;
    if (mem_wr_en && mem_wr_ready) begin
      if (a_wn < 4096) begin
        a_wa[a_wn] = mem_wr_addr;
        a_wd[a_wn] = mem_wr_data;
      end
      a_wn++;
    end
    if (fetch_buf_kill) kill_cnt++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [31:0] tgt);
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 64; s++)
        for (int w = 0; w < 4; w++) begin
          m_val[c][s][w] = ($urandom % 4) != 0;
          if ($urandom % 2) m_tag[c][s][w] = {tgt[31:13], 3'($urandom % 8)};
          else              m_tag[c][s][w] = 22'($urandom);
          m_dirty[c][s][w] = 4'($urandom);
          for (int l = 0; l < 4; l++) m_data[c][s][w][l] = $urandom;
        end
  endtask

  task automatic expect_op(input logic [15:0] op, input logic [31:0] addr, input logic pg);
    logic [31:0] span, base, a;
    int steps;
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 64; s++)
        for (int w = 0; w < 4; w++) begin
          e_val[c][s][w] = m_val[c][s][w];
          e_dirty[c][s][w] = m_dirty[c][s][w];
        end
    e_wn = 0; e_rd = 0; e_clr = 0;
    for (int k = 0; k < 2; k++) begin
      if (op[6+k]) begin
        if (op[4:3] == 2'b11) begin
          e_clr_sel[e_clr] = k[0];
          e_clr++;
          for (int s = 0; s < 64; s++)
            for (int w = 0; w < 4; w++) e_val[k][s][w] = 1'b0;
        end else begin
          span  = (op[4:3] == 2'b10) ? (pg ? 32'd8192 : 32'd4096) : 32'd16;
          steps = int'(span / 16);
          base  = addr & ~(span - 1);
          for (int j = 0; j < steps; j++) begin
            a = base + 32'(j * 16);
            e_rd++;
            for (int w = 0; w < 4; w++) begin
              if (e_val[k][a[9:4]][w] && m_tag[k][a[9:4]][w] == a[31:10]) begin
                for (int l = 0; l < 4; l++) begin
                  if (e_dirty[k][a[9:4]][w][l] && op[5]) begin
                    e_wa[e_wn] = a + 32'(l * 4);
                    e_wd[e_wn] = m_data[k][a[9:4]][w][l];
                    e_wn++;
                  end
                end
                e_dirty[k][a[9:4]][w] = 4'h0;
                e_val[k][a[9:4]][w] = 1'b0;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic run_op(input logic [15:0] op, input logic pg, input logic [31:0] tgt,
                        input bit intrude, input string tag);
    int n, bad;
    preload(tgt);
    for (int r = 0; r < 8; r++) areg_flat[r*32 +: 32] = $urandom;
    areg_flat[op[2:0]*32 +: 32] = tgt;
    expect_op(op, tgt, pg);
    a_wn = 0; rd_cnt = 0; clr_cnt = 0; kill_cnt = 0; hold_viol = 0;
    @(negedge clk);
    opcode = op; page8k = pg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", {tag, " busy after start"}, busy, 1);
    if (intrude) begin
      repeat (3) @(negedge clk);
      opcode = 16'h00D8; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 60000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1 && busy == 1'b0, "R10", {tag, " done with busy low"}, {busy, done}, 1);
    @(negedge clk);
    check(done == 1'b0, "R10", {tag, " done single cycle"}, done, 0);
    check(kill_cnt == 1, "R9", {tag, " fetch kill pulses"}, kill_cnt, 1);
    check(hold_viol == 0, "R8", {tag, " write held until ready"}, hold_viol, 0);
    check(rd_cnt == e_rd, "R4", {tag, " array reads (R3 line / R4 page)"}, rd_cnt, e_rd);
    check(clr_cnt == e_clr, "R2", {tag, " flash clears"}, clr_cnt, e_clr);
    for (int i = 0; i < e_clr && i < clr_cnt; i++)
      check(clr_sel_log[i] == e_clr_sel[i], "R1", {tag, " clear order"}, clr_sel_log[i], e_clr_sel[i]);
    bad = 0;
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 64; s++)
        for (int w = 0; w < 4; w++)
          if (m_val[c][s][w] != e_val[c][s][w] || m_dirty[c][s][w] != e_dirty[c][s][w]) bad++;
    check(bad == 0, "R6", {tag, " valid/dirty mismatches (R5 register pick)"}, bad, 0);
    check(a_wn == e_wn, "R7", {tag, " write-back count"}, a_wn, e_wn);
    bad = 0;
    for (int i = 0; i < e_wn && i < a_wn && i < 4096; i++)
      if (a_wa[i] != e_wa[i] || a_wd[i] != e_wd[i]) bad++;
    check(bad == 0, "R7", {tag, " write-back order/addr/data"}, bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      mem_wr_ready = ($urandom % 4) != 0;
    end
  end

  initial begin
    logic [15:0] op;
    void'($urandom(32'd20240611));
    prev_hold = 1'b0; prev_addr = '0; prev_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && mem_wr_en == 1'b0 && arr_rd_en == 1'b0,
          "R10", "reset state idle", {busy, done, mem_wr_en, arr_rd_en}, 0);

    // R1: no cache selected, upper opcode bits set
    run_op(16'hA53A, 1'b0, 32'h0012_3454, 1'b0, "R1 none selected");
    // R2: whole scope both caches with push
    run_op(16'h00F8, 1'b0, 32'h0040_0000, 1'b0, "R2 whole both");
    // R3: single line, data cache, push, register 7
    run_op(16'h006F, 1'b0, 32'h0100_2A3C, 1'b0, "R3 line data push r7");
    // R3: scope value 1 also means line, instruction cache
    run_op(16'h00AA, 1'b1, 32'h0100_47F8, 1'b0, "R3 line scope1 instr");
    // R4: 4 KB page, instruction cache, push
    run_op(16'h00B1, 1'b0, 32'h0077_5ABC, 1'b0, "R4 page4k instr");
    // R4: 8 KB page, both caches, push
    run_op(16'h00F3, 1'b1, 32'h0077_5ABC, 1'b0, "R4 page8k both");
    // R6: page invalidate only, both caches
    run_op(16'h00D5, 1'b1, 32'h0321_0000, 1'b0, "R6 page no push");
    // R10: start during busy ignored
    run_op(16'h0074, 1'b0, 32'h0055_1230, 1'b1, "R10 start while busy");

    for (int i = 0; i < 20; i++) begin
      op = 16'($urandom);
      if (op[4:3] == 2'b10 && (i % 3) != 0) op[4:3] = 2'b00;
      run_op(op, 1'($urandom), {12'h004, 20'($urandom)}, 1'b0, "R5 random");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule